// File: doc/BRIEF.md
# Conditional Execute Unit with Shifted Second Operand

This block is the data-processing stage of a small 32-bit processor pipeline. Each cycle it takes one decoded operation: a 4-bit opcode, a 4-bit condition, a set-flags bit, the first operand, and the fields that form the second operand. The second operand is either a register value put through a barrel shifter or an 8-bit constant rotated right by an even distance. The block returns the result and a write enable for the destination register in the same cycle. It keeps the four condition flags (negative, zero, carry, overflow) in a register of its own, which is updated on the clock edge.

Before anything takes effect, the condition is tested against the stored flags. If the condition fails, the operation becomes a no-op: there is no register write and no flag change. Four compare-style opcodes only set the flags. The register file, fetch, decode, multiply and memory access sit outside this block.

Top module: `cond_alu_exec`

## Requirements
- R1: Arithmetic opcodes give the following results, where a is op1, b is the second operand and C is the stored carry: 2 gives a-b, 3 gives b-a, 4 gives a+b, 5 gives a+b+C, 6 gives a-b-(1-C), 7 gives b-a-(1-C).
- R2: Logical opcodes give the following results: 0 gives a AND b, 1 gives a XOR b, 12 gives a OR b, 13 gives b, 14 gives a AND NOT b, 15 gives NOT b.
- R3: Opcodes 8 (test AND), 9 (test XOR), 10 (compare a-b) and 11 (compare a+b) never raise rd_we_o. They update the flags whether set_flags_i is 0 or 1, and result_o shows the computed value.
- R4: All other opcodes update the flags only when set_flags_i is 1. The register write happens regardless of set_flags_i.
- R5: On a flag update, Z (flags_o bit 2) is set exactly when the 32-bit result is zero, and N (flags_o bit 3) takes result bit 31.
- R6: For add-type operations, C (flags_o bit 1) is the carry out. For subtract-type operations, C is 1 when no borrow occurs. V (flags_o bit 0) is signed overflow.
- R7: Logical and test opcodes load C from the second-operand carry and leave V unchanged.
- R8: Condition encodings: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always, 15 never.
- R9: When the condition fails, the operation writes no register and leaves the flags unchanged, even when set_flags_i is 1.
- R10: Immediate shift distances 1..31 apply a shift selected by shift_kind_i (0 left logical, 1 right logical, 2 right arithmetic, 3 rotate right). The carry is the last bit shifted out. A distance of 0 passes rm_i through unchanged and leaves the carry equal to the stored C.
- R11: A shift distance taken from shift_reg_byte_i is handled as follows. 0 passes rm_i through with carry equal to C. For left or right logical shifts, 32 gives 0 with the carry equal to the edge bit, and more than 32 gives 0 with carry 0. Right arithmetic by 32 or more fills with the sign bit, and the carry is the sign. Rotate uses the distance mod 32, and the carry is bit 31 of the result.
- R12: With op2_imm_sel_i set, the second operand is imm_val_i rotated right by 2*imm_rot_i. Its carry is bit 31 of that value, or the stored C when imm_rot_i is 0.
- R13: After reset the flags are 0000. With issue_i low, rd_we_o is 0 and the flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | An operation is presented this cycle |
| opcode_i | input | 4 | Operation select |
| cond_i | input | 4 | Execution condition |
| set_flags_i | input | 1 | Request a flag update |
| op1_i | input | 32 | First operand |
| op2_imm_sel_i | input | 1 | 1: rotated constant, 0: shifted register |
| imm_val_i | input | 8 | Constant byte |
| imm_rot_i | input | 4 | Constant rotation, in steps of two bits |
| rm_i | input | 32 | Register value to be shifted |
| shift_kind_i | input | 2 | Shift type |
| shift_by_reg_i | input | 1 | 1: distance from shift_reg_byte_i |
| shift_amt_i | input | 5 | Immediate shift distance |
| shift_reg_byte_i | input | 8 | Low byte of the shift-distance register |
| result_o | output | 32 | Computed value |
| rd_we_o | output | 1 | Destination register write enable |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The bench targets four groups of corner cases.

- **Borrow sense.** It checks the carry-in of subtract-with-carry and reverse subtract-with-carry under both carry states. A design that treated carry as borrow would be off by one in those results, and would report C inverted after a subtraction.
- **Condition table.** It sweeps all sixteen conditions across six flag states. A mixed-up signed comparison would fire GE/LT or GT/LE on the wrong states. A missing never-code would execute under encoding 15.
- **Shifter boundaries.** It covers register distances of exactly 32, more than 32, and 0. A shifter that truncated the distance to five bits would return the unshifted value, or a wrong carry, in those cases.
- **Suppression.** It checks that a failed condition with the set-flags bit on, or a compare with the bit off, leaves the flags exactly as expected.

// File: rtl/cond_alu_pkg.sv
`timescale 1ns/1ps
package cond_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0, SH_LSR = 2'd1, SH_ASR = 2'd2, SH_ROR = 2'd3
    } shift_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0, CIN_ONE = 2'd1, CIN_FLAG = 2'd2
    } cin_sel_e;

    // How the shared adder is steered for one opcode
    typedef struct packed {
        logic     swap;    // operands exchanged (reverse forms)
        logic     invert;  // second adder input inverted (subtract forms)
        cin_sel_e cin;
    } arith_plan_t;

    function automatic logic is_compare(alu_op_e op);
        return op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN};
    endfunction

    function automatic logic is_arith(alu_op_e op);
        return op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC,
                          OP_SBC, OP_RSC, OP_CMP, OP_CMN};
    endfunction

    function automatic arith_plan_t plan_arith(alu_op_e op);
        arith_plan_t p;
        p.swap   = 1'b0;
        p.invert = 1'b0;
        p.cin    = CIN_ZERO;
        case (op)
            OP_SUB, OP_CMP: begin p.invert = 1'b1; p.cin = CIN_ONE;  end
            OP_RSB:         begin p.swap = 1'b1; p.invert = 1'b1; p.cin = CIN_ONE; end
            OP_ADC:         begin p.cin = CIN_FLAG; end
            OP_SBC:         begin p.invert = 1'b1; p.cin = CIN_FLAG; end
            OP_RSC:         begin p.swap = 1'b1; p.invert = 1'b1; p.cin = CIN_FLAG; end
            default:        ;
        endcase
        return p;
    endfunction

    function automatic logic cond_holds(cond_e cc, nzcv_t f);
        case (cc)
            CC_EQ:   return f.z;
            CC_NE:   return !f.z;
            CC_CS:   return f.c;
            CC_CC:   return !f.c;
            CC_MI:   return f.n;
            CC_PL:   return !f.n;
            CC_VS:   return f.v;
            CC_VC:   return !f.v;
            CC_HI:   return f.c && !f.z;
            CC_LS:   return !f.c || f.z;
            CC_GE:   return f.n == f.v;
            CC_LT:   return f.n != f.v;
            CC_GT:   return !f.z && (f.n == f.v);
            CC_LE:   return f.z || (f.n != f.v);
            CC_AL:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cau_cond_gate.sv
`timescale 1ns/1ps
module cau_cond_gate
    import cond_alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] cond_i,
    input  nzcv_t      flags_i,
    output logic       pass_o
);

    cond_e cc;
    assign cc     = cond_e'(cond_i);
    assign pass_o = cond_holds(cc, flags_i);

    // R8
    always_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_i == 4'd14) |-> pass_o);

    // R8
    never_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_i == 4'd15) |-> !pass_o);

endmodule

// File: rtl/cau_operand2.sv
`timescale 1ns/1ps
module cau_operand2
    import cond_alu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 8,
    parameter int ROT_W   = 4,
    parameter int AMT_W   = 8,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               imm_sel_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic [ROT_W-1:0]   rot_i,
    input  logic [DATA_W-1:0]  rm_i,
    input  logic [1:0]         kind_i,
    input  logic               by_reg_i,
    input  logic [SHAMT_W-1:0] amt_imm_i,
    input  logic [AMT_W-1:0]   amt_reg_i,
    input  logic               c_in,
    output logic [DATA_W-1:0]  op2_o,
    output logic               carry_o
);

    localparam logic [AMT_W-1:0] AMT_FULL = AMT_W'(DATA_W);

    shift_e                    kind;
    logic [AMT_W-1:0]          amt;
    logic [AMT_W-1:0]          asr_amt;
    logic [DATA_W:0]           lsl_w;
    logic [DATA_W:0]           lsr_w;
    logic signed [DATA_W:0]    asr_w;
    logic [2*DATA_W-1:0]       ror_w;
    logic [DATA_W-1:0]         sh_val;
    logic                      sh_c;

    logic [DATA_W-1:0]         imm_ext;
    logic [SHAMT_W-1:0]        imm_dist;
    logic [2*DATA_W-1:0]       imm_w;
    logic [DATA_W-1:0]         imm_val;
    logic                      imm_c;

    assign kind = shift_e'(kind_i);
    assign amt  = by_reg_i ? amt_reg_i
                           : {{(AMT_W-SHAMT_W){1'b0}}, amt_imm_i};

    // Register path: barrel shifter with the carry kept one bit beyond the data
    always_comb begin
        lsl_w   = '0;
        lsr_w   = '0;
        asr_w   = '0;
        ror_w   = '0;
        asr_amt = '0;
        sh_val  = rm_i;
        sh_c    = c_in;
        if (amt != '0) begin
            unique case (kind)
                SH_LSL: begin
                    if (amt > AMT_FULL) begin
                        sh_val = '0;
                        sh_c   = 1'b0;
                    end else begin
                        lsl_w  = {1'b0, rm_i} << amt;
                        sh_val = lsl_w[DATA_W-1:0];
                        sh_c   = lsl_w[DATA_W];
                    end
                end
                SH_LSR: begin
                    if (amt > AMT_FULL) begin
                        sh_val = '0;
                        sh_c   = 1'b0;
                    end else begin
                        lsr_w  = {rm_i, 1'b0} >> amt;
                        sh_val = lsr_w[DATA_W:1];
                        sh_c   = lsr_w[0];
                    end
                end
                SH_ASR: begin
                    asr_amt = (amt > AMT_FULL) ? AMT_FULL : amt;
                    asr_w   = $signed({rm_i, 1'b0}) >>> asr_amt;
                    sh_val  = asr_w[DATA_W:1];
                    sh_c    = asr_w[0];
                end
                SH_ROR: begin
                    ror_w  = {rm_i, rm_i} >> amt[SHAMT_W-1:0];
                    sh_val = ror_w[DATA_W-1:0];
                    sh_c   = ror_w[DATA_W-1];
                end
                default: ;
            endcase
        end
    end

    // Constant path: byte rotated right by twice the rotation field
    assign imm_ext  = {{(DATA_W-IMM_W){1'b0}}, imm_i};
    assign imm_dist = SHAMT_W'({rot_i, 1'b0});
    assign imm_w    = {imm_ext, imm_ext} >> imm_dist;
    assign imm_val  = imm_w[DATA_W-1:0];
    assign imm_c    = (rot_i == '0) ? c_in : imm_val[DATA_W-1];

    assign op2_o   = imm_sel_i ? imm_val : sh_val;
    assign carry_o = imm_sel_i ? imm_c   : sh_c;

    // R12
    rot0_imm_chk: assert property (@(posedge clk) disable iff (rst)
        (imm_sel_i && rot_i == '0) |-> (op2_o == imm_ext && carry_o == c_in));

    // R11
    lsl_far_chk: assert property (@(posedge clk) disable iff (rst)
        (!imm_sel_i && by_reg_i && kind_i == 2'd0 && amt_reg_i > AMT_FULL)
        |-> (op2_o == '0 && !carry_o));

endmodule

// File: rtl/cau_alu_core.sv
`timescale 1ns/1ps
module cau_alu_core
    import cond_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sh_carry_i,
    input  logic              c_in,
    input  logic              v_in,
    output logic [DATA_W-1:0] result_o,
    output nzcv_t             flags_o
);

    arith_plan_t       plan;
    logic [DATA_W-1:0] x, y;
    logic              cin;
    logic [DATA_W:0]   sum;
    logic              ovf;

    always_comb begin
        plan = plan_arith(op_i);
        x    = plan.swap ? b_i : a_i;
        y    = plan.swap ? a_i : b_i;
        if (plan.invert) y = ~y;
        case (plan.cin)
            CIN_ONE:  cin = 1'b1;
            CIN_FLAG: cin = c_in;
            default:  cin = 1'b0;
        endcase
        sum = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
        ovf = (x[DATA_W-1] == y[DATA_W-1]) && (sum[DATA_W-1] != x[DATA_W-1]);
    end

    always_comb begin
        case (op_i)
            OP_AND, OP_TST: result_o = a_i & b_i;
            OP_EOR, OP_TEQ: result_o = a_i ^ b_i;
            OP_ORR:         result_o = a_i | b_i;
            OP_MOV:         result_o = b_i;
            OP_BIC:         result_o = a_i & ~b_i;
            OP_MVN:         result_o = ~b_i;
            default:        result_o = sum[DATA_W-1:0];
        endcase
    end

    always_comb begin
        flags_o.n = result_o[DATA_W-1];
        flags_o.z = (result_o == '0);
        if (is_arith(op_i)) begin
            flags_o.c = sum[DATA_W];
            flags_o.v = ovf;
        end else begin
            flags_o.c = sh_carry_i;
            flags_o.v = v_in;
        end
    end

endmodule

// File: rtl/cond_alu_exec.sv
`timescale 1ns/1ps
module cond_alu_exec
    import cond_alu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 8,
    parameter int ROT_W   = 4,
    parameter int AMT_W   = 8,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               issue_i,
    input  logic [3:0]         opcode_i,
    input  logic [3:0]         cond_i,
    input  logic               set_flags_i,
    input  logic [DATA_W-1:0]  op1_i,
    input  logic               op2_imm_sel_i,
    input  logic [IMM_W-1:0]   imm_val_i,
    input  logic [ROT_W-1:0]   imm_rot_i,
    input  logic [DATA_W-1:0]  rm_i,
    input  logic [1:0]         shift_kind_i,
    input  logic               shift_by_reg_i,
    input  logic [SHAMT_W-1:0] shift_amt_i,
    input  logic [AMT_W-1:0]   shift_reg_byte_i,
    output logic [DATA_W-1:0]  result_o,
    output logic               rd_we_o,
    output logic [3:0]         flags_o
);

    alu_op_e           op;
    nzcv_t             flags_q;
    nzcv_t             alu_flags;
    logic              cond_pass;
    logic              cmp_op;
    logic              flag_upd;
    logic [DATA_W-1:0] op2;
    logic              op2_carry;

    assign op     = alu_op_e'(opcode_i);
    assign cmp_op = is_compare(op);

    cau_cond_gate u_cond (
        .clk     (clk),
        .rst     (rst),
        .cond_i  (cond_i),
        .flags_i (flags_q),
        .pass_o  (cond_pass)
    );

    cau_operand2 #(
        .DATA_W  (DATA_W),
        .IMM_W   (IMM_W),
        .ROT_W   (ROT_W),
        .AMT_W   (AMT_W),
        .SHAMT_W (SHAMT_W)
    ) u_op2 (
        .clk       (clk),
        .rst       (rst),
        .imm_sel_i (op2_imm_sel_i),
        .imm_i     (imm_val_i),
        .rot_i     (imm_rot_i),
        .rm_i      (rm_i),
        .kind_i    (shift_kind_i),
        .by_reg_i  (shift_by_reg_i),
        .amt_imm_i (shift_amt_i),
        .amt_reg_i (shift_reg_byte_i),
        .c_in      (flags_q.c),
        .op2_o     (op2),
        .carry_o   (op2_carry)
    );

    cau_alu_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .op_i       (op),
        .a_i        (op1_i),
        .b_i        (op2),
        .sh_carry_i (op2_carry),
        .c_in       (flags_q.c),
        .v_in       (flags_q.v),
        .result_o   (result_o),
        .flags_o    (alu_flags)
    );

    assign flag_upd = issue_i && cond_pass && (set_flags_i || cmp_op);
    assign rd_we_o  = issue_i && cond_pass && !cmp_op;

    always_ff @(posedge clk) begin
        if (rst)           flags_q <= '0;
        else if (flag_upd) flags_q <= alu_flags;
    end

    assign flags_o = flags_q;

    // R9
    fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_i && !cond_pass) |=> $stable(flags_q));

    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !issue_i |-> !rd_we_o ##1 $stable(flags_q));

    // R3
    cmp_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_i && opcode_i[3:2] == 2'b10) |-> !rd_we_o);

    // R4
    no_s_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_i && !set_flags_i && opcode_i[3:2] != 2'b10) |=> $stable(flags_q));

    // R5
    nz_track_chk: assert property (@(posedge clk) disable iff (rst)
        flag_upd |=> (flags_q.z == ($past(result_o) == '0)
                      && flags_q.n == $past(result_o[DATA_W-1])));

    // R7
    logic_v_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_upd && !is_arith(op)) |=> (flags_q.v == $past(flags_q.v)));

endmodule

// File: tb/sim_cond_alu_exec.sv
`timescale 1ns/1ps
module sim_cond_alu_exec;
    import cond_alu_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        issue;
    logic [3:0]  opc, cc;
    logic        sbit;
    logic [31:0] op1;
    logic        isel;
    logic [7:0]  imm8;
    logic [3:0]  rot;
    logic [31:0] rm;
    logic [1:0]  skind;
    logic        sreg;
    logic [4:0]  samt;
    logic [7:0]  rsb;
    logic [31:0] result;
    logic        rd_we;
    logic [3:0]  flags;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cond_alu_exec u0 (
        .clk(clk), .rst(rst), .issue_i(issue), .opcode_i(opc), .cond_i(cc),
        .set_flags_i(sbit), .op1_i(op1), .op2_imm_sel_i(isel), .imm_val_i(imm8),
        .imm_rot_i(rot), .rm_i(rm), .shift_kind_i(skind), .shift_by_reg_i(sreg),
        .shift_amt_i(samt), .shift_reg_byte_i(rsb), .result_o(result),
        .rd_we_o(rd_we), .flags_o(flags)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic set_reg(input logic [31:0] v);
        isel = 0; rm = v; skind = 2'd0; sreg = 0; samt = 5'd0; rsb = 8'd0;
    endtask
    task automatic set_sh(input logic [1:0] k, input logic [4:0] n, input logic [31:0] v);
        isel = 0; skind = k; sreg = 0; samt = n; rm = v;
    endtask
    task automatic set_rsh(input logic [1:0] k, input logic [7:0] r, input logic [31:0] v);
        isel = 0; skind = k; sreg = 1; rsb = r; rm = v;
    endtask
    task automatic set_imm(input logic [7:0] i, input logic [3:0] r);
        isel = 1; imm8 = i; rot = r;
    endtask

    // Called one time unit after a rising edge; returns at the same phase.
    task automatic fire(input logic [3:0] op, input logic [3:0] c, input logic s,
                        input logic [31:0] a, input logic [31:0] er, input logic ew,
                        input logic [3:0] ef, input string req);
        opc = op; cc = c; sbit = s; op1 = a; issue = 1;
        #1;
        if (ew || op[3:2] == 2'b10) check({req, " result"}, result, er);
        check({req, " write"}, {31'b0, rd_we}, {31'b0, ew});
        @(posedge clk); #1;
        issue = 0;
        check({req, " flags"}, {28'b0, flags}, {28'b0, ef});
    endtask

    // Bring the flags to a known state with compares (R3, R6)
    task automatic prime(input logic [3:0] st);
        case (st)
            4'b0000: begin set_reg(32'd1);        fire(OP_CMN, 14, 0, 32'd1,        32'd2,        0, st, "R6 prime"); end
            4'b0010: begin set_reg(32'd3);        fire(OP_CMP, 14, 0, 32'd5,        32'd2,        0, st, "R6 prime"); end
            4'b0110: begin set_reg(32'd5);        fire(OP_CMP, 14, 0, 32'd5,        32'd0,        0, st, "R6 prime"); end
            4'b1000: begin set_reg(32'd5);        fire(OP_CMP, 14, 0, 32'd3,        32'hFFFFFFFE, 0, st, "R6 prime"); end
            4'b1001: begin set_reg(32'd1);        fire(OP_CMN, 14, 0, 32'h7FFFFFFF, 32'h80000000, 0, st, "R6 prime"); end
            4'b0011: begin set_reg(32'd1);        fire(OP_CMP, 14, 0, 32'h80000000, 32'h7FFFFFFF, 0, st, "R6 prime"); end
            default: begin set_reg(32'hFFFFFFFF); fire(OP_CMN, 14, 0, 32'hFFFFFFFF, 32'hFFFFFFFE, 0, 4'b1010, "R6 prime"); end
        endcase
    endtask

    task automatic t_reset;
        issue = 0; set_reg(32'd0); opc = 4'd4; cc = 4'd14; sbit = 1; op1 = 0;
        isel = 0; imm8 = 0; rot = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        check("R13 reset flags", {28'b0, flags}, 32'd0);
        check("R13 idle write", {31'b0, rd_we}, 32'd0);
        @(posedge clk); #1;
        prime(4'b0110);
        set_reg(32'd1); opc = OP_ADD; cc = 4'd14; sbit = 1; op1 = 32'd1; issue = 0;
        #1 check("R13 idle write", {31'b0, rd_we}, 32'd0);
        @(posedge clk); #1;
        check("R13 idle flags", {28'b0, flags}, 32'b0110);
    endtask

    task automatic t_arith;
        prime(4'b0010);
        set_reg(32'd2);  fire(OP_ADC, 14, 0, 32'd1,  32'd4, 1, 4'b0010, "R1 adc c1");
        set_reg(32'd3);  fire(OP_SBC, 14, 0, 32'd10, 32'd7, 1, 4'b0010, "R1 sbc c1");
        set_reg(32'd10); fire(OP_RSC, 14, 0, 32'd3,  32'd7, 1, 4'b0010, "R1 rsc c1");
        set_reg(32'd3);  fire(OP_SUB, 14, 0, 32'd10, 32'd7, 1, 4'b0010, "R1 sub");
        set_reg(32'd3);  fire(OP_RSB, 14, 0, 32'd10, 32'hFFFFFFF9, 1, 4'b0010, "R1 rsb");
        set_reg(32'd9);  fire(OP_ADD, 14, 0, 32'd9,  32'd18, 1, 4'b0010, "R1 add");
        prime(4'b1000);
        set_reg(32'd2);  fire(OP_ADC, 14, 0, 32'd1,  32'd3, 1, 4'b1000, "R1 adc c0");
        set_reg(32'd3);  fire(OP_SBC, 14, 0, 32'd10, 32'd6, 1, 4'b1000, "R1 sbc c0");
        set_reg(32'd10); fire(OP_RSC, 14, 0, 32'd3,  32'd6, 1, 4'b1000, "R1 rsc c0");
    endtask

    task automatic t_arith_flags;
        prime(4'b0000);
        set_reg(32'd5);          fire(OP_SUB, 14, 1, 32'd3, 32'hFFFFFFFE, 1, 4'b1000, "R6 subs borrow");
        set_reg(32'd5);          fire(OP_SUB, 14, 1, 32'd5, 32'd0, 1, 4'b0110, "R6 subs equal");
        set_reg(32'd1);          fire(OP_ADD, 14, 1, 32'hFFFFFFFF, 32'd0, 1, 4'b0110, "R6 adds carry");
        set_reg(32'd1);          fire(OP_ADD, 14, 1, 32'h7FFFFFFF, 32'h80000000, 1, 4'b1001, "R6 adds ovf");
        set_reg(32'h80000000);   fire(OP_RSB, 14, 1, 32'd1, 32'h7FFFFFFF, 1, 4'b0011, "R6 rsbs ovf");
        set_reg(32'd0);          fire(OP_SBC, 14, 1, 32'd0, 32'd0, 1, 4'b0110, "R6 sbcs c1");
        prime(4'b1000);
        set_reg(32'd0);          fire(OP_SBC, 14, 1, 32'd0, 32'hFFFFFFFF, 1, 4'b1000, "R6 sbcs c0");
        set_reg(32'd0);          fire(OP_ADC, 14, 1, 32'h7FFFFFFF, 32'h7FFFFFFF, 1, 4'b0000, "R6 adcs c0");
    endtask

    task automatic t_logic;
        prime(4'b0000);
        set_reg(32'h0FF00FF0);
        fire(OP_AND, 14, 0, 32'hFF00FF00, 32'h0F000F00, 1, 4'b0000, "R2 and");
        fire(OP_EOR, 14, 0, 32'hFF00FF00, 32'hF0F0F0F0, 1, 4'b0000, "R2 eor");
        fire(OP_ORR, 14, 0, 32'hFF00FF00, 32'hFFF0FFF0, 1, 4'b0000, "R2 orr");
        fire(OP_BIC, 14, 0, 32'hFF00FF00, 32'hF000F000, 1, 4'b0000, "R2 bic");
        fire(OP_MVN, 14, 0, 32'hDEADBEEF, 32'hF00FF00F, 1, 4'b0000, "R2 mvn");
        set_reg(32'h12345678);
        fire(OP_MOV, 14, 0, 32'hDEADBEEF, 32'h12345678, 1, 4'b0000, "R2 mov");
    endtask

    task automatic t_compare_and_s;
        prime(4'b0000);
        set_reg(32'd5);        fire(OP_CMP, 14, 0, 32'd5, 32'd0, 0, 4'b0110, "R3 cmp no s");
        prime(4'b1001);
        set_reg(32'h0F);       fire(OP_TST, 14, 0, 32'hF0, 32'd0, 0, 4'b0101, "R3 tst");
        set_reg(32'd0);        fire(OP_TEQ, 14, 1, 32'h80000000, 32'h80000000, 0, 4'b1001, "R3 teq");
        prime(4'b0110);
        set_reg(32'd4);        fire(OP_ADD, 14, 0, 32'd3, 32'd7, 1, 4'b0110, "R4 add no s");
        set_imm(8'd0, 4'd0);   fire(OP_MOV, 14, 0, 32'd0, 32'd0, 1, 4'b0110, "R4 mov no s");
        set_reg(32'd4);        fire(OP_ADD, 14, 1, 32'd3, 32'd7, 1, 4'b0000, "R4 adds");
    endtask

    task automatic t_logic_flags;
        prime(4'b1001);
        set_sh(2'd0, 5'd4, 32'h1000000F);
        fire(OP_AND, 14, 1, 32'hFF, 32'hF0, 1, 4'b0011, "R7 ands carry");
        set_reg(32'd0);
        fire(OP_MOV, 14, 1, 32'd0, 32'd0, 1, 4'b0111, "R7 movs keep c");
        set_imm(8'd0, 4'd0);
        fire(OP_MVN, 14, 1, 32'd0, 32'hFFFFFFFF, 1, 4'b1011, "R7 mvns");
        set_imm(8'h04, 4'd1);
        fire(OP_MOV, 14, 1, 32'd0, 32'd1, 1, 4'b0001, "R12 imm carry");
    endtask

    task automatic t_imm;
        prime(4'b0000);
        set_imm(8'h03, 4'd0);  fire(OP_ADD, 14, 0, 32'd5, 32'd8, 1, 4'b0000, "R12 add imm");
        set_imm(8'h01, 4'd6);  fire(OP_MOV, 14, 0, 32'd0, 32'h00100000, 1, 4'b0000, "R12 rot 12");
        set_imm(8'hFF, 4'd1);  fire(OP_MOV, 14, 0, 32'd0, 32'hC000003F, 1, 4'b0000, "R12 rot 2");
        set_imm(8'h3C, 4'd15); fire(OP_MOV, 14, 0, 32'd0, 32'h000000F0, 1, 4'b0000, "R12 rot 30");
        set_imm(8'h02, 4'd1);  fire(OP_MOV, 14, 1, 32'd0, 32'h80000000, 1, 4'b1010, "R12 movs c");
    endtask

    task automatic t_shift_imm;
        prime(4'b0000);
        set_sh(2'd0, 5'd4,  32'h12345678); fire(OP_MOV, 14, 0, 0, 32'h23456780, 1, 4'b0000, "R10 lsl");
        set_sh(2'd1, 5'd4,  32'h80000010); fire(OP_MOV, 14, 0, 0, 32'h08000001, 1, 4'b0000, "R10 lsr");
        set_sh(2'd2, 5'd4,  32'h80000010); fire(OP_MOV, 14, 0, 0, 32'hF8000001, 1, 4'b0000, "R10 asr");
        set_sh(2'd3, 5'd8,  32'h12345678); fire(OP_MOV, 14, 0, 0, 32'h78123456, 1, 4'b0000, "R10 ror");
        set_sh(2'd1, 5'd1,  32'h00000003); fire(OP_MOV, 14, 1, 0, 32'd1, 1, 4'b0010, "R10 lsr carry");
        set_sh(2'd2, 5'd31, 32'h80000000); fire(OP_MOV, 14, 1, 0, 32'hFFFFFFFF, 1, 4'b1000, "R10 asr 31");
        set_sh(2'd0, 5'd0,  32'd0);        fire(OP_MOV, 14, 1, 0, 32'd0, 1, 4'b0100, "R10 zero dist c0");
        prime(4'b0010);
        set_sh(2'd3, 5'd0,  32'd5);        fire(OP_MOV, 14, 1, 0, 32'd5, 1, 4'b0010, "R10 zero dist c1");
    endtask

    task automatic t_shift_reg;
        prime(4'b0000);
        set_rsh(2'd0, 8'd33, 32'hFFFFFFFF); fire(OP_MOV, 14, 1, 0, 32'd0, 1, 4'b0100, "R11 lsl 33");
        set_rsh(2'd0, 8'd32, 32'd1);        fire(OP_MOV, 14, 1, 0, 32'd0, 1, 4'b0110, "R11 lsl 32");
        set_rsh(2'd1, 8'd32, 32'h80000000); fire(OP_MOV, 14, 1, 0, 32'd0, 1, 4'b0110, "R11 lsr 32");
        set_rsh(2'd1, 8'd200, 32'hFFFFFFFF); fire(OP_MOV, 14, 1, 0, 32'd0, 1, 4'b0100, "R11 lsr 200");
        set_rsh(2'd2, 8'd40, 32'h80000000); fire(OP_MOV, 14, 1, 0, 32'hFFFFFFFF, 1, 4'b1010, "R11 asr 40");
        set_rsh(2'd3, 8'd32, 32'h80000001); fire(OP_MOV, 14, 1, 0, 32'h80000001, 1, 4'b1010, "R11 ror 32");
        set_rsh(2'd3, 8'd36, 32'h000000F1); fire(OP_MOV, 14, 1, 0, 32'h1000000F, 1, 4'b0000, "R11 ror 36");
        prime(4'b0010);
        set_rsh(2'd1, 8'd0, 32'd7);         fire(OP_MOV, 14, 1, 0, 32'd7, 1, 4'b0010, "R11 dist 0");
    endtask

    task automatic cond_sweep(input logic [3:0] st, input logic [15:0] mask);
        prime(st);
        set_reg(32'd1);
        for (int c = 0; c < 16; c++)
            fire(OP_ADD, 4'(c), 0, 32'd1, 32'd2, mask[c], st, "R8 cond");
    endtask

    task automatic t_suppress;
        prime(4'b0110);
        set_reg(32'd1);  fire(OP_ADD, 4'd1,  1, 32'd1, 32'd2, 0, 4'b0110, "R9 failed adds");
        prime(4'b0010);
        set_reg(32'd5);  fire(OP_SUB, 4'd15, 1, 32'd5, 32'd0, 0, 4'b0010, "R9 never subs");
        set_reg(32'd5);  fire(OP_CMP, 4'd0,  0, 32'd5, 32'd0, 0, 4'b0010, "R9 failed cmp");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset;
        t_arith;
        t_arith_flags;
        t_logic;
        t_compare_and_s;
        t_logic_flags;
        t_imm;
        t_shift_imm;
        t_shift_reg;
        cond_sweep(4'b0000, 16'h56AA);
        cond_sweep(4'b0110, 16'h66A5);
        cond_sweep(4'b0010, 16'h55A6);
        cond_sweep(4'b1001, 16'h565A);
        cond_sweep(4'b1000, 16'h6A9A);
        cond_sweep(4'b0011, 16'h6966);
        t_suppress;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule